// File: doc/BRIEF.md
# Descriptor-Ring Memory Copy Engine

This block is a memory-to-memory copy engine with a single physical channel. Software lays out two rings of descriptors in memory: a source ring whose entries name source buffers and a destination ring whose entries name destination buffers. Slot `i` of one ring pairs with slot `i` of the other. Software programs each ring's base address, entry count and software index through a 32-bit register port. Writing the source ring's software index hands new descriptors to the engine. For each slot the engine fetches both descriptors and copies the data one 32-bit word at a time. It then writes a done flag together with the copied length back into the destination descriptor, and advances its hardware indices.

Each descriptor is four little-endian 32-bit words. Word 0 holds the buffer address. Word 1 carries a 14-bit byte length in bits 29:16, and the destination descriptor also carries the done flag in word 1. The memory side is a word-wide request port: a request and its address, write enable and write data are held until the memory answers with `mem_ack`. On a read, `mem_rdata` is valid in the same cycle as `mem_ack`.

The controller has eight states, each named after the access it makes. `ST_IDLE` moves to `ST_SRC_PTR` when work is allowed. `ST_SRC_PTR` reads source word 0, then `ST_SRC_LEN` reads source word 1, then `ST_DST_PTR` reads destination word 0, then `ST_DST_FLAG` reads destination word 1. From `ST_DST_FLAG` the engine returns to `ST_IDLE` if the done flag is still set, goes to `ST_MARK` if the length is zero, and otherwise goes to `ST_MOVE_RD`. `ST_MOVE_RD` reads one source word and moves to `ST_MOVE_WR`. `ST_MOVE_WR` writes that word and then goes either back to `ST_MOVE_RD` or on to `ST_MARK` after the last word. `ST_MARK` writes the done word and returns to `ST_IDLE`. Every transition out of a state other than `ST_IDLE` waits for `mem_ack`.

Top module: `ring_copy_engine`

## Requirements
- R1: After reset every register reads zero, the engine is idle and `mem_req` stays low; no memory request is issued while the engine is idle.
- R2: Each ring has four registers at fixed offsets. The source ring sits at 0x000 and the destination ring at 0x100. Within a ring, base is at +0x0, count at +0x4, software index at +0x8 and hardware index at +0xC. Base, count and software index read back what was written. Writes to the hardware index have no effect.
- R3: A new slot is started only when the source enable (bit 0 of 0x204) and the destination enable (bit 2 of 0x204) are both 1, and the source hardware index differs from the source software index.
- R4: Let L be the length in bits 29:16 of source word 1, limited to 0x3F80. The engine copies L/4 words, reading from the source address and writing to the destination address, with both addresses rising by 4 per word.
- R5: After the copy the engine writes destination word 1 of the slot with the done flag set and L in bits 29:16. The done flag is bit 31 by default and bit 15 when `DONE_HI` is 0.
- R6: After the done write, both hardware indices advance to (idx+1) AND (count-1), using the source ring count, so they wrap to 0 after the last slot.
- R7: The engine never starts the slot whose index equals the destination software index, so one slot always stays empty.
- R8: If destination word 1 of a slot already has the done flag set, the engine makes no writes and does not advance. It retries until software clears the flag.
- R9: Bit 1 of 0x204 (source busy) is 1 while a slot is in progress. Bit 3 (destination busy) is 1 from the destination pointer fetch until the done write. If the enables are cleared during a slot, that slot still finishes, the busy bits then fall, and no further slot is started.
- R10: Writing 0x208 with bit 0 set clears the source hardware index. Writing it with bit 16 set clears the destination hardware index. The register reads zero.
- R11: A memory request keeps its address, direction and write data unchanged until it is acknowledged, and the copy result does not depend on how many cycles the acknowledge takes.
- R12: A zero-length slot makes no data accesses but still receives its done write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory request completes this cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
The assertions assume that the memory answers a held request with `mem_ack` in some later cycle. They also assume that the source ring count is a power of two no larger than 2^IDX_W, and that software does not pulse the index clears in the same cycle that the engine completes a slot. The bench keeps within these assumptions. Its memory model only acknowledges a live request, and in one phase it withholds the acknowledge every third cycle. The bench programs a count of 8 and writes the clear register only while the engine is idle and disabled. All buffer addresses and lengths in the bench are word aligned.

// File: rtl/ring_copy_pkg.sv
package ring_copy_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SRC_PTR,
        ST_SRC_LEN,
        ST_DST_PTR,
        ST_DST_FLAG,
        ST_MOVE_RD,
        ST_MOVE_WR,
        ST_MARK
    } eng_state_e;

    localparam logic [11:0] OFF_SRC_RING = 12'h000;
    localparam logic [11:0] OFF_DST_RING = 12'h100;
    localparam logic [3:0]  BANK_BASE    = 4'h0;
    localparam logic [3:0]  BANK_COUNT   = 4'h4;
    localparam logic [3:0]  BANK_SWIDX   = 4'h8;
    localparam logic [3:0]  BANK_HWIDX   = 4'hC;
    localparam logic [11:0] OFF_CTRL     = 12'h204;
    localparam logic [11:0] OFF_CLEAR    = 12'h208;

    localparam int LEN_W  = 14;
    localparam int WORD_W = LEN_W - 2;

endpackage

// File: rtl/ring_cfg_regs.sv
module ring_cfg_regs
    import ring_copy_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [11:0]      addr,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] src_hw_idx,
    input  logic [IDX_W-1:0] dst_hw_idx,
    input  logic             src_busy,
    input  logic             dst_busy,
    output logic [31:0]      src_base,
    output logic [31:0]      dst_base,
    output logic [IDX_W-1:0] idx_mask,
    output logic [IDX_W-1:0] src_sw_idx,
    output logic [IDX_W-1:0] dst_sw_idx,
    output logic             src_en,
    output logic             dst_en,
    output logic             src_clr,
    output logic             dst_clr,
    output logic [31:0]      rdata
);

    localparam int CNT_PAD = 32 - IDX_W - 1;
    localparam int IDX_PAD = 32 - IDX_W;

    logic [1:0][31:0] bank_rd;
    logic [1:0]       bank_hit;
    logic             src_en_q;
    logic             dst_en_q;

    for (genvar g = 0; g < 2; g++) begin : g_bank
        localparam logic [11:0] ORG = (g == 0) ? OFF_SRC_RING : OFF_DST_RING;

        logic [31:0]      base_q;
        logic [IDX_W:0]   cnt_q;
        logic [IDX_W-1:0] sw_q;
        logic [IDX_W-1:0] hw_idx;
        logic             hit;

        assign hw_idx = (g == 0) ? src_hw_idx : dst_hw_idx;
        assign hit    = (addr[11:4] == ORG[11:4]);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q <= '0;
                cnt_q  <= '0;
                sw_q   <= '0;
            end else if (wr_en && hit) begin
                if (addr[3:0] == BANK_BASE)  base_q <= wdata;
                if (addr[3:0] == BANK_COUNT) cnt_q  <= wdata[IDX_W:0];
                if (addr[3:0] == BANK_SWIDX) sw_q   <= wdata[IDX_W-1:0];
            end
        end

        always_comb begin
            bank_rd[g] = '0;
            case (addr[3:0])
                BANK_BASE:  bank_rd[g] = base_q;
                BANK_COUNT: bank_rd[g] = {{CNT_PAD{1'b0}}, cnt_q};
                BANK_SWIDX: bank_rd[g] = {{IDX_PAD{1'b0}}, sw_q};
                BANK_HWIDX: bank_rd[g] = {{IDX_PAD{1'b0}}, hw_idx};
                default:    bank_rd[g] = '0;
            endcase
        end

        assign bank_hit[g] = hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_en_q <= 1'b0;
            dst_en_q <= 1'b0;
        end else if (wr_en && addr == OFF_CTRL) begin
            src_en_q <= wdata[0];
            dst_en_q <= wdata[2];
        end
    end

    assign src_base   = g_bank[0].base_q;
    assign dst_base   = g_bank[1].base_q;
    assign src_sw_idx = g_bank[0].sw_q;
    assign dst_sw_idx = g_bank[1].sw_q;
    assign idx_mask   = g_bank[0].cnt_q[IDX_W-1:0] - 1'b1;
    assign src_en     = src_en_q;
    assign dst_en     = dst_en_q;
    assign src_clr    = wr_en && (addr == OFF_CLEAR) && wdata[0];
    assign dst_clr    = wr_en && (addr == OFF_CLEAR) && wdata[16];

    always_comb begin
        rdata = '0;
        if (bank_hit[0]) begin
            rdata = bank_rd[0];
        end else if (bank_hit[1]) begin
            rdata = bank_rd[1];
        end else if (addr == OFF_CTRL) begin
            rdata = {28'h0, dst_busy, dst_en_q, src_busy, src_en_q};
        end
    end

endmodule

// File: rtl/ring_copy_fsm.sv
module ring_copy_fsm
    import ring_copy_pkg::*;
#(
    parameter int IDX_W    = 12,
    parameter int DONE_BIT = 31,
    parameter int MAX_LEN  = 16'h3F80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      src_base,
    input  logic [31:0]      dst_base,
    input  logic [IDX_W-1:0] idx_mask,
    input  logic [IDX_W-1:0] src_sw_idx,
    input  logic [IDX_W-1:0] dst_sw_idx,
    input  logic             src_en,
    input  logic             dst_en,
    input  logic             src_clr,
    input  logic             dst_clr,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    output logic [IDX_W-1:0] src_hw_idx,
    output logic [IDX_W-1:0] dst_hw_idx,
    output logic             src_busy,
    output logic             dst_busy
);

    localparam int          SLOT_PAD  = 32 - IDX_W - 4;
    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);
    localparam logic [31:0] DONE_MASK = 32'h1 << DONE_BIT;

    eng_state_e       state_q, state_d;
    logic [31:0]      src_ptr_q;
    logic [31:0]      dst_ptr_q;
    logic [31:0]      data_q;
    logic [LEN_W-1:0] len_q;
    logic [WORD_W-1:0] words_q;
    logic [IDX_W-1:0] src_idx_q;
    logic [IDX_W-1:0] dst_idx_q;

    logic [31:0]      slot_off;
    logic [31:0]      src_desc;
    logic [31:0]      dst_desc;
    logic [LEN_W-1:0] len_raw;
    logic [LEN_W-1:0] len_lim;
    logic             go;

    assign slot_off = {{SLOT_PAD{1'b0}}, src_idx_q, 4'h0};
    assign src_desc = src_base + slot_off;
    assign dst_desc = dst_base + slot_off;
    assign len_raw  = mem_rdata[29:16];
    assign len_lim  = (len_raw > LEN_CAP) ? LEN_CAP : len_raw;
    assign go       = src_en && dst_en
                   && (src_idx_q != src_sw_idx)
                   && (src_idx_q != dst_sw_idx);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (go) state_d = ST_SRC_PTR;
            ST_SRC_PTR:  if (mem_ack) state_d = ST_SRC_LEN;
            ST_SRC_LEN:  if (mem_ack) state_d = ST_DST_PTR;
            ST_DST_PTR:  if (mem_ack) state_d = ST_DST_FLAG;
            ST_DST_FLAG: begin
                if (mem_ack) begin
                    if (mem_rdata[DONE_BIT])  state_d = ST_IDLE;
                    else if (words_q == '0)   state_d = ST_MARK;
                    else                      state_d = ST_MOVE_RD;
                end
            end
            ST_MOVE_RD:  if (mem_ack) state_d = ST_MOVE_WR;
            ST_MOVE_WR: begin
                if (mem_ack) begin
                    if (words_q == WORD_W'(1)) state_d = ST_MARK;
                    else                       state_d = ST_MOVE_RD;
                end
            end
            ST_MARK:     if (mem_ack) state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            ST_IDLE:     mem_req  = 1'b0;
            ST_SRC_PTR:  mem_addr = src_desc;
            ST_SRC_LEN:  mem_addr = src_desc + 32'd4;
            ST_DST_PTR:  mem_addr = dst_desc;
            ST_DST_FLAG: mem_addr = dst_desc + 32'd4;
            ST_MOVE_RD:  mem_addr = src_ptr_q;
            ST_MOVE_WR: begin
                mem_we    = 1'b1;
                mem_addr  = dst_ptr_q;
                mem_wdata = data_q;
            end
            ST_MARK: begin
                mem_we    = 1'b1;
                mem_addr  = dst_desc + 32'd4;
                mem_wdata = DONE_MASK | {2'b00, len_q, 16'h0000};
            end
        endcase
        src_busy = (state_q != ST_IDLE);
        dst_busy = (state_q != ST_IDLE) && (state_q != ST_SRC_PTR)
                && (state_q != ST_SRC_LEN);
    end

    // datapath and indices
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_ptr_q <= '0;
            dst_ptr_q <= '0;
            data_q    <= '0;
            len_q     <= '0;
            words_q   <= '0;
            src_idx_q <= '0;
            dst_idx_q <= '0;
        end else begin
            if (mem_ack) begin
                unique case (state_q)
                    ST_SRC_PTR: src_ptr_q <= mem_rdata;
                    ST_SRC_LEN: begin
                        len_q   <= len_lim;
                        words_q <= len_lim[LEN_W-1:2];
                    end
                    ST_DST_PTR: dst_ptr_q <= mem_rdata;
                    ST_MOVE_RD: data_q    <= mem_rdata;
                    ST_MOVE_WR: begin
                        src_ptr_q <= src_ptr_q + 32'd4;
                        dst_ptr_q <= dst_ptr_q + 32'd4;
                        words_q   <= words_q - 1'b1;
                    end
                    ST_MARK: begin
                        src_idx_q <= (src_idx_q + 1'b1) & idx_mask;
                        dst_idx_q <= (dst_idx_q + 1'b1) & idx_mask;
                    end
                    default: ;
                endcase
            end
            if (src_clr) src_idx_q <= '0;
            if (dst_clr) dst_idx_q <= '0;
        end
    end

    assign src_hw_idx = src_idx_q;
    assign dst_hw_idx = dst_idx_q;

endmodule

// File: rtl/ring_copy_engine.sv
module ring_copy_engine #(
    parameter int IDX_W   = 12,
    parameter bit DONE_HI = 1'b1,
    parameter int MAX_LEN = 16'h3F80
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);

    localparam int DONE_BIT = DONE_HI ? 31 : 15;

    logic [31:0]      src_base_w;
    logic [31:0]      dst_base_w;
    logic [IDX_W-1:0] idx_mask_w;
    logic [IDX_W-1:0] src_sw_idx_w;
    logic [IDX_W-1:0] dst_sw_idx_w;
    logic [IDX_W-1:0] src_hw_idx_w;
    logic [IDX_W-1:0] dst_hw_idx_w;
    logic             src_en_w;
    logic             dst_en_w;
    logic             src_clr_w;
    logic             dst_clr_w;
    logic             src_busy_w;
    logic             dst_busy_w;

    ring_cfg_regs #(.IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .src_hw_idx (src_hw_idx_w),
        .dst_hw_idx (dst_hw_idx_w),
        .src_busy   (src_busy_w),
        .dst_busy   (dst_busy_w),
        .src_base   (src_base_w),
        .dst_base   (dst_base_w),
        .idx_mask   (idx_mask_w),
        .src_sw_idx (src_sw_idx_w),
        .dst_sw_idx (dst_sw_idx_w),
        .src_en     (src_en_w),
        .dst_en     (dst_en_w),
        .src_clr    (src_clr_w),
        .dst_clr    (dst_clr_w),
        .rdata      (reg_rdata)
    );

    ring_copy_fsm #(
        .IDX_W    (IDX_W),
        .DONE_BIT (DONE_BIT),
        .MAX_LEN  (MAX_LEN)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_base   (src_base_w),
        .dst_base   (dst_base_w),
        .idx_mask   (idx_mask_w),
        .src_sw_idx (src_sw_idx_w),
        .dst_sw_idx (dst_sw_idx_w),
        .src_en     (src_en_w),
        .dst_en     (dst_en_w),
        .src_clr    (src_clr_w),
        .dst_clr    (dst_clr_w),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .src_hw_idx (src_hw_idx_w),
        .dst_hw_idx (dst_hw_idx_w),
        .src_busy   (src_busy_w),
        .dst_busy   (dst_busy_w)
    );

endmodule

// File: rtl/ring_copy_chk.sv
module ring_copy_chk #(
    parameter int IDX_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req,
    input logic             mem_we,
    input logic [31:0]      mem_addr,
    input logic [31:0]      mem_wdata,
    input logic             mem_ack,
    input logic [IDX_W-1:0] src_hw_idx,
    input logic [IDX_W-1:0] src_sw_idx,
    input logic [IDX_W-1:0] dst_sw_idx,
    input logic [IDX_W-1:0] idx_mask,
    input logic             src_clr,
    input logic             src_en,
    input logic             dst_en,
    input logic             src_busy
);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !src_busy |-> !mem_req);

    // R3
    start_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_busy) |-> $past(src_en && dst_en && (src_hw_idx != src_sw_idx)));

    // R7
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_busy) |-> $past(src_hw_idx != dst_sw_idx));

    // R6
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_hw_idx != $past(src_hw_idx)) && !$past(src_clr))
            |-> (src_hw_idx == (($past(src_hw_idx) + 1'b1) & $past(idx_mask))));

endmodule

bind ring_copy_engine ring_copy_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .src_hw_idx (src_hw_idx_w),
    .src_sw_idx (src_sw_idx_w),
    .dst_sw_idx (dst_sw_idx_w),
    .idx_mask   (idx_mask_w),
    .src_clr    (src_clr_w),
    .src_en     (src_en_w),
    .dst_en     (dst_en_w),
    .src_busy   (src_busy_w)
);

// File: tb/tb_ring_copy_engine.sv
module tb_ring_copy_engine;

    localparam time CLK_P = 20ns;
    localparam logic [31:0] SRC_RING = 32'h0000_0000;
    localparam logic [31:0] DST_RING = 32'h0000_0400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] d;
    } wr_t;

    wr_t         exp_q[$];
    logic [31:0] mem [0:32767];
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    bit          stall_mode = 1'b0;

    ring_copy_engine dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata)
    );

    always #(CLK_P / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // memory model and write monitor (scoreboard consumer)
    always @(negedge clk) begin
        wr_t e;
        if (mem_req && !(stall_mode && (cyc % 3 == 0))) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[16:2]] = mem_wdata;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R4 or R5 unexpected write act %h:%h exp none",
                             mem_addr, mem_wdata);
                end else begin
                    e = exp_q.pop_front();
                    if (e.a != mem_addr || e.d != mem_wdata) begin
                        errors++;
                        $display("FAIL R4 or R5 or R11 write act %h:%h exp %h:%h",
                                 mem_addr, mem_wdata, e.a, e.d);
                    end
                end
            end else begin
                mem_rdata <= mem[mem_addr[16:2]];
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act %h exp %h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #2ns;
        v = reg_rdata;
    endtask

    function automatic logic [31:0] pat(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction

    // lays out a slot pair and the source data
    task automatic add_desc(input int slot, input logic [31:0] s, input logic [31:0] d,
                            input logic [13:0] len);
        mem[(SRC_RING + 16 * slot) >> 2]     = s;
        mem[(SRC_RING + 16 * slot + 4) >> 2] = {2'b00, len, 16'h0};
        mem[(DST_RING + 16 * slot) >> 2]     = d;
        mem[(DST_RING + 16 * slot + 4) >> 2] = 32'h0;
        for (int k = 0; k < 4096; k++) begin
            if (4 * k < int'(len)) mem[(s >> 2) + k] = pat(s + 4 * k);
        end
    endtask

    // driver side of the scoreboard
    task automatic push_exp(input int slot, input logic [31:0] s, input logic [31:0] d,
                            input logic [13:0] len);
        logic [13:0] l;
        l = (len > 14'h3F80) ? 14'h3F80 : len;
        for (int k = 0; k < int'(l) / 4; k++) begin
            exp_q.push_back('{a: d + 4 * k, d: pat(s + 4 * k)});
        end
        exp_q.push_back('{a: DST_RING + 16 * slot + 4, d: 32'h8000_0000 | {2'b00, l, 16'h0}});
    endtask

    task automatic wait_idx(input logic [31:0] v, input int maxc, input string tag);
        logic [31:0] r;
        r = '1;
        for (int i = 0; i < maxc; i++) begin
            reg_rd(12'h00C, r);
            if (r == v) break;
        end
        check_eq(tag, r, v);
    endtask

    initial begin
        #(CLK_P * 190000);
        errors++;
        $display("FAIL watchdog R1 act 0 exp 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int          n;
        for (int i = 0; i < 32768; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_rd(12'h000, r); check_eq("R1 src base", r, 0);
        reg_rd(12'h104, r); check_eq("R1 dst count", r, 0);
        reg_rd(12'h204, r); check_eq("R1 ctrl", r, 0);
        check_eq("R1 mem_req", {31'h0, mem_req}, 0);

        // R2 programming and readback
        reg_wr(12'h000, SRC_RING);
        reg_wr(12'h004, 8);
        reg_wr(12'h008, 0);
        reg_wr(12'h100, DST_RING);
        reg_wr(12'h104, 8);
        reg_wr(12'h108, 7);
        reg_rd(12'h100, r); check_eq("R2 dst base", r, DST_RING);
        reg_rd(12'h004, r); check_eq("R2 src count", r, 8);
        reg_rd(12'h108, r); check_eq("R2 dst sw idx", r, 7);
        reg_wr(12'h00C, 5);
        reg_rd(12'h00C, r); check_eq("R2 hw idx ignores write", r, 0);

        // R3 disabled engine does not start
        add_desc(0, 32'h4000, 32'h6000, 14'd32);
        reg_wr(12'h008, 1);
        repeat (50) @(negedge clk);
        reg_rd(12'h00C, r); check_eq("R3 disabled no advance", r, 0);
        push_exp(0, 32'h4000, 32'h6000, 14'd32);
        reg_wr(12'h204, 32'h5);
        wait_idx(1, 500, "R6 advance after slot 0");

        // R4 R11 R12 with stalled memory
        stall_mode = 1'b1;
        add_desc(1, 32'h4100, 32'h6100, 14'd32);
        add_desc(2, 32'h4200, 32'h6200, 14'd0);
        add_desc(3, 32'h8000, 32'h10000, 14'h3FFC);
        push_exp(1, 32'h4100, 32'h6100, 14'd32);
        push_exp(2, 32'h4200, 32'h6200, 14'd0);
        push_exp(3, 32'h8000, 32'h10000, 14'h3FFC);
        reg_wr(12'h008, 4);
        wait_idx(4, 20000, "R11 stalled copies complete");
        stall_mode = 1'b0;
        check_eq("R12 zero-length done word", mem[(DST_RING + 16 * 2 + 4) >> 2], 32'h8000_0000);
        check_eq("R4 clamped length", mem[(DST_RING + 16 * 3 + 4) >> 2], 32'hBF80_0000);

        // R7 overrun guard, then R6 wrap
        for (int s = 4; s < 8; s++) add_desc(s, 32'h4000 + 32'h100 * s, 32'h6000 + 32'h100 * s, 14'd16);
        for (int s = 4; s < 7; s++) push_exp(s, 32'h4000 + 32'h100 * s, 32'h6000 + 32'h100 * s, 14'd16);
        reg_wr(12'h008, 0);
        wait_idx(7, 500, "R7 stops before reserved slot");
        repeat (40) @(negedge clk);
        reg_rd(12'h00C, r); check_eq("R7 still held at reserved slot", r, 7);
        push_exp(7, 32'h4700, 32'h6700, 14'd16);
        reg_wr(12'h108, 3);
        wait_idx(0, 500, "R6 wrap to zero");

        // R8 done flag still set
        add_desc(0, 32'h4800, 32'h6800, 14'd8);
        mem[(DST_RING + 4) >> 2] = 32'h8000_0000;
        n = 0;
        reg_wr(12'h008, 1);
        repeat (40) @(negedge clk);
        reg_rd(12'h00C, r); check_eq("R8 stalled on done flag", r, 0);
        check_eq("R8 no writes while flagged", exp_q.size(), n);
        push_exp(0, 32'h4800, 32'h6800, 14'd8);
        mem[(DST_RING + 4) >> 2] = 32'h0;
        wait_idx(1, 500, "R8 proceeds after clear");

        // R9 busy and drain
        add_desc(1, 32'h5000, 32'h7000, 14'd256);
        push_exp(1, 32'h5000, 32'h7000, 14'd256);
        reg_wr(12'h008, 2);
        repeat (10) @(negedge clk);
        reg_rd(12'h204, r); check_eq("R9 busy while copying", r, 32'hF);
        reg_wr(12'h204, 0);
        wait_idx(2, 1000, "R9 in-flight slot drains");
        reg_rd(12'h204, r); check_eq("R9 busy drops", r, 0);
        add_desc(2, 32'h5400, 32'h7400, 14'd8);
        reg_wr(12'h008, 3);
        repeat (40) @(negedge clk);
        reg_rd(12'h00C, r); check_eq("R9 no start after disable", r, 2);

        // R10 index clears
        reg_wr(12'h208, 32'h0000_0001);
        reg_rd(12'h00C, r); check_eq("R10 src idx cleared", r, 0);
        reg_rd(12'h10C, r); check_eq("R10 dst idx kept", r, 2);
        reg_wr(12'h208, 32'h0001_0000);
        reg_rd(12'h10C, r); check_eq("R10 dst idx cleared", r, 0);
        reg_rd(12'h208, r); check_eq("R10 clear reads zero", r, 0);

        check_eq("R5 scoreboard drained", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule